// File: doc/BRIEF.md
# Super-I/O Configuration Port Controller

This block is the configuration access path of a legacy Super-I/O style device. It sits behind a pair of adjacent host I/O addresses. The lower address is an index port and the one above it is a data port. A strap input picks which of two base addresses the pair answers at: 0x2E or 0x4E. The host talks to it through a plain read/write strobe interface.

Configuration access stays closed until the host writes the entry key 0x87 to the index port twice with no other write in between. While access is open, a write to the index port selects a configuration register, and data-port reads and writes reach that register. Writing the exit key 0xAA to the index port closes access again.

Registers below 0x30 are global and are answered here. These are the logical-device selector at 0x07 and the read-only identification bytes at 0x20 to 0x24. Registers from 0x30 upward belong to whichever logical device the selector names. For those registers the block only forwards the index, the write data and the read/write strobes outward, and it returns the device's read data to the host. On a typical part the general-purpose I/O function is logical device 0x06.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset, cfg_open is 0, ld_sel is 0x00 and io_rdata is 0xFF.
- R2: Two index-port writes of 0x87 with no other write between them set cfg_open on the clock edge that takes the second write.
- R3: While the port is not open, any write between the two 0x87 keys aborts the unlock, and two fresh keys are needed. This covers an index write of any other value and any data-port write.
- R4: An index-port write of 0xAA while open clears cfg_open on that edge. Later data-port reads then return 0xFF.
- R5: While closed, every read of the port pair returns 0xFF. Data-port writes change no register, and dev_wr and dev_rd stay low.
- R6: With strap_alt=0 the index and data ports are 0x2E and 0x2F. With strap_alt=1 they are 0x4E and 0x4F. Accesses to any other address change nothing, and reads of other addresses return 0xFF.
- R7: While open, a data write with index 0x07 loads ld_sel on that edge, and a data read with index 0x07 returns it.
- R8: While open, data reads return the following bytes by index: 0x20 gives the device ID high byte, 0x21 the device ID low byte, 0x22 the revision, 0x23 the manufacturer ID high byte (0x19) and 0x24 its low byte (0x34). Writes to these indexes have no effect.
- R9: While open with index at or above 0x30, a data write drives dev_wr high for exactly the strobe cycle, with dev_idx equal to the index and dev_wdata equal to the host data. A data read drives dev_rd and returns dev_rdata.
- R10: Indexes below 0x30 never raise dev_wr or dev_rd. A data read of an unassigned global index returns 0x00.
- R11: io_rdata takes its new value on the clock edge of the read strobe and holds it until the next read.
- R12: While open, an index-port read returns the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Base select: 0 gives 0x2E, 1 gives 0x4E |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Registered host read data |
| cfg_open | output | 1 | Configuration access open |
| ld_sel | output | 8 | Selected logical device |
| dev_idx | output | 8 | Index forwarded to logical devices |
| dev_wdata | output | 8 | Write data forwarded to logical devices |
| dev_wr | output | 1 | Forwarded register write strobe |
| dev_rd | output | 1 | Forwarded register read strobe |
| dev_rdata | input | 8 | Read data from the selected logical device, same cycle |

## Verification
Write effects on cfg_open, ld_sel and the index register are due on the clock edge that takes the write strobe. The bench raises each strobe at a falling edge and drops it at the next falling edge, and it samples state at that second falling edge, one full register stage later. Read data is also registered on the strobe's edge, so each read is compared at the falling edge that ends its strobe. The forwarded strobes dev_wr and dev_rd are combinational with the host strobe, so they are sampled shortly after the strobe is raised and before the next rising edge.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] KEY_ENTER    = 8'h87;
  localparam logic [7:0] KEY_EXIT     = 8'hAA;
  localparam logic [7:0] REG_LDSEL    = 8'h07;
  localparam logic [7:0] REG_DEVID_HI = 8'h20;
  localparam logic [7:0] REG_DEVID_LO = 8'h21;
  localparam logic [7:0] REG_REV      = 8'h22;
  localparam logic [7:0] REG_MFR_HI   = 8'h23;
  localparam logic [7:0] REG_MFR_LO   = 8'h24;
  localparam logic [7:0] RD_IDLE      = 8'hFF;

endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode #(
  parameter int unsigned   ADDR_W   = 16,
  parameter logic [15:0]   BASE_PRI = 16'h002E,
  parameter logic [15:0]   BASE_ALT = 16'h004E
) (
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              idx_wr,
  output logic              idx_rd,
  output logic              dat_wr,
  output logic              dat_rd
);

  localparam logic [ADDR_W-1:0] PRI_IDX = ADDR_W'(BASE_PRI);
  localparam logic [ADDR_W-1:0] PRI_DAT = ADDR_W'(BASE_PRI + 16'd1);
  localparam logic [ADDR_W-1:0] ALT_IDX = ADDR_W'(BASE_ALT);
  localparam logic [ADDR_W-1:0] ALT_DAT = ADDR_W'(BASE_ALT + 16'd1);

  logic [ADDR_W-1:0] idx_addr;
  logic [ADDR_W-1:0] dat_addr;
  logic              hit_idx;
  logic              hit_dat;

  always_comb begin
    idx_addr = strap_alt ? ALT_IDX : PRI_IDX;
    dat_addr = strap_alt ? ALT_DAT : PRI_DAT;
    hit_idx  = (io_addr == idx_addr);
    hit_dat  = (io_addr == dat_addr);
    idx_wr   = io_wr & hit_idx;
    idx_rd   = io_rd & hit_idx;
    dat_wr   = io_wr & hit_dat;
    dat_rd   = io_rd & hit_dat;
  end

endmodule

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open,
  output logic       idx_load
);

  key_state_e state_q;
  key_state_e state_d;
  logic       state_en;

  always_comb begin
    state_d  = state_q;
    idx_load = 1'b0;
    unique case (state_q)
      KEY_LOCKED: begin
        if (idx_wr && wdata == KEY_ENTER) state_d = KEY_HALF;
      end
      KEY_HALF: begin
        if (idx_wr && wdata == KEY_ENTER) state_d = KEY_OPEN;
        else if (idx_wr || dat_wr)        state_d = KEY_LOCKED;
      end
      KEY_OPEN: begin
        if (idx_wr) begin
          if (wdata == KEY_EXIT) state_d  = KEY_LOCKED;
          else                   idx_load = 1'b1;
        end
      end
      default: state_d = KEY_LOCKED;
    endcase
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= KEY_LOCKED;
    else if (state_en) state_q <= state_d;
  end

  assign cfg_open = (state_q == KEY_OPEN);

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] DEV_ID    = 16'hC3A5,
  parameter logic [7:0]  DEV_REV   = 8'h17,
  parameter logic [15:0] MFR_ID    = 16'h1934,
  parameter logic [7:0]  FWD_START = 8'h30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_open,
  input  logic       idx_load,
  input  logic       dat_wr,
  input  logic       idx_rd,
  input  logic       dat_rd,
  input  logic       any_rd,
  input  logic [7:0] wdata,
  input  logic [7:0] dev_rdata,
  output logic [7:0] idx_q,
  output logic [7:0] ldsel_q,
  output logic       dev_wr,
  output logic       dev_rd,
  output logic [7:0] rdata_q
);

  localparam int unsigned ID_BYTES = 5;

  logic [7:0] id_byte [ID_BYTES];
  logic [7:0] id_value;
  logic [7:0] glb_value;
  logic [7:0] rd_value;
  logic [7:0] idx_d, ldsel_d, rdata_d;
  logic       idx_en, ldsel_en, rdata_en;
  logic       fwd;

  assign id_byte[0] = DEV_ID[15:8];
  assign id_byte[1] = DEV_ID[7:0];
  assign id_byte[2] = DEV_REV;
  assign id_byte[3] = MFR_ID[15:8];
  assign id_byte[4] = MFR_ID[7:0];

  always_comb begin
    id_value = 8'h00;
    for (int i = 0; i < ID_BYTES; i++) begin
      if (idx_q == REG_DEVID_HI + 8'(i)) id_value = id_byte[i];
    end
  end

  always_comb begin
    fwd    = (idx_q >= FWD_START);
    dev_wr = dat_wr & cfg_open & fwd;
    dev_rd = dat_rd & cfg_open & fwd;
  end

  always_comb begin
    if (idx_q == REG_LDSEL) glb_value = ldsel_q;
    else                    glb_value = id_value;
    if (!cfg_open)          rd_value = RD_IDLE;
    else if (idx_rd)        rd_value = idx_q;
    else if (dat_rd)        rd_value = fwd ? dev_rdata : glb_value;
    else                    rd_value = RD_IDLE;
  end

  always_comb begin
    idx_en   = idx_load;
    idx_d    = wdata;
    ldsel_en = dat_wr & cfg_open & (idx_q == REG_LDSEL);
    ldsel_d  = wdata;
    rdata_en = any_rd;
    rdata_d  = rd_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= 8'h00;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ldsel_q <= 8'h00;
    else if (ldsel_en) ldsel_q <= ldsel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= RD_IDLE;
    else if (rdata_en) rdata_q <= rdata_d;
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] BASE_PRI  = 16'h002E,
  parameter logic [15:0] BASE_ALT  = 16'h004E,
  parameter logic [15:0] DEV_ID    = 16'hC3A5,
  parameter logic [7:0]  DEV_REV   = 8'h17,
  parameter logic [15:0] MFR_ID    = 16'h1934,
  parameter logic [7:0]  FWD_START = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              cfg_open,
  output logic [7:0]        ld_sel,
  output logic [7:0]        dev_idx,
  output logic [7:0]        dev_wdata,
  output logic              dev_wr,
  output logic              dev_rd,
  input  logic [7:0]        dev_rdata
);

  logic idx_wr, idx_rd, dat_wr, dat_rd;
  logic idx_load;

  sio_port_decode #(
    .ADDR_W  (ADDR_W),
    .BASE_PRI(BASE_PRI),
    .BASE_ALT(BASE_ALT)
  ) u_decode (
    .strap_alt(strap_alt),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .idx_wr   (idx_wr),
    .idx_rd   (idx_rd),
    .dat_wr   (dat_wr),
    .dat_rd   (dat_rd)
  );

  sio_key_fsm u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_wr  (idx_wr),
    .dat_wr  (dat_wr),
    .wdata   (io_wdata),
    .cfg_open(cfg_open),
    .idx_load(idx_load)
  );

  sio_cfg_regs #(
    .DEV_ID   (DEV_ID),
    .DEV_REV  (DEV_REV),
    .MFR_ID   (MFR_ID),
    .FWD_START(FWD_START)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_open (cfg_open),
    .idx_load (idx_load),
    .dat_wr   (dat_wr),
    .idx_rd   (idx_rd),
    .dat_rd   (dat_rd),
    .any_rd   (io_rd),
    .wdata    (io_wdata),
    .dev_rdata(dev_rdata),
    .idx_q    (dev_idx),
    .ldsel_q  (ld_sel),
    .dev_wr   (dev_wr),
    .dev_rd   (dev_rd),
    .rdata_q  (io_rdata)
  );

  assign dev_wdata = io_wdata;

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter logic [7:0] FWD_START = 8'h30
) (
  input logic       clk,
  input logic       rst_n,
  input logic       io_wr,
  input logic       io_rd,
  input logic [7:0] io_wdata,
  input logic [7:0] io_rdata,
  input logic       cfg_open,
  input logic [7:0] ld_sel,
  input logic [7:0] dev_idx,
  input logic       dev_wr,
  input logic       dev_rd
);

  // R2: opening is always caused by an entry-key write
  assert_open_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && io_wdata == 8'h87));

  // R4: closing is always caused by an exit-key write
  assert_close_by_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_open) |-> $past(io_wr && io_wdata == 8'hAA));

  // R5: no forwarding while closed
  assert_no_fwd_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |-> (!dev_wr && !dev_rd));

  // R5: reads while closed give the idle byte
  assert_idle_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_rd) |=> (io_rdata == 8'hFF));

  // R9: forwarded writes only in the device range
  assert_fwd_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr || dev_rd) |-> (dev_idx >= FWD_START));

  // R7: selector only changes on a host write
  assert_ldsel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(ld_sel));

  // R11: read data holds between reads
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

endmodule

bind sio_cfg_port sio_cfg_port_chk #(.FWD_START(FWD_START)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .io_wr   (io_wr),
  .io_rd   (io_rd),
  .io_wdata(io_wdata),
  .io_rdata(io_rdata),
  .cfg_open(cfg_open),
  .ld_sel  (ld_sel),
  .dev_idx (dev_idx),
  .dev_wr  (dev_wr),
  .dev_rd  (dev_rd)
);

// File: tb/tb_sio_cfg_port.sv
module tb_sio_cfg_port;

  logic        clk;
  logic        rst_n;
  logic        strap_alt;
  logic [15:0] io_addr;
  logic        io_wr;
  logic        io_rd;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic        cfg_open;
  logic [7:0]  ld_sel;
  logic [7:0]  dev_idx;
  logic [7:0]  dev_wdata;
  logic        dev_wr;
  logic        dev_rd;
  logic [7:0]  dev_rdata;

  int n_checks;
  int n_fail;
  bit done;

  sio_cfg_port dut (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .cfg_open(cfg_open), .ld_sel(ld_sel), .dev_idx(dev_idx),
    .dev_wdata(dev_wdata), .dev_wr(dev_wr), .dev_rd(dev_rd),
    .dev_rdata(dev_rdata)
  );

  // logical device model: answers with index xor 0x5A
  assign dev_rdata = dev_idx ^ 8'h5A;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // op: 0 write, 1 read+compare, 2 check cfg_open, 3 check ld_sel
  // fields: {req[3:0], op[1:0], addr[15:0], data[7:0], exp[7:0]}
  localparam int NV = 36;
  localparam logic [37:0] VEC [NV] = '{
    {4'd5,  2'd1, 16'h002F, 8'h00, 8'hFF}, // R5 closed read
    {4'd5,  2'd0, 16'h002E, 8'h07, 8'h00}, // R5
    {4'd5,  2'd0, 16'h002F, 8'h33, 8'h00}, // R5 closed write
    {4'd5,  2'd3, 16'h0000, 8'h00, 8'h00}, // R5 ld_sel untouched
    {4'd3,  2'd0, 16'h002E, 8'h87, 8'h00}, // R3
    {4'd3,  2'd0, 16'h002E, 8'h12, 8'h00}, // R3 abort
    {4'd3,  2'd0, 16'h002E, 8'h87, 8'h00}, // R3
    {4'd3,  2'd2, 16'h0000, 8'h00, 8'h00}, // R3 still closed
    {4'd3,  2'd0, 16'h002F, 8'h00, 8'h00}, // R3 data write aborts
    {4'd3,  2'd0, 16'h002E, 8'h87, 8'h00}, // R3
    {4'd3,  2'd2, 16'h0000, 8'h00, 8'h00}, // R3
    {4'd2,  2'd0, 16'h002E, 8'h87, 8'h00}, // R2
    {4'd2,  2'd2, 16'h0000, 8'h00, 8'h01}, // R2 open
    {4'd8,  2'd0, 16'h002E, 8'h20, 8'h00}, // R8
    {4'd8,  2'd1, 16'h002F, 8'h00, 8'hC3}, // R8 id high
    {4'd8,  2'd0, 16'h002E, 8'h21, 8'h00}, // R8
    {4'd8,  2'd1, 16'h002F, 8'h00, 8'hA5}, // R8 id low
    {4'd8,  2'd0, 16'h002E, 8'h22, 8'h00}, // R8
    {4'd8,  2'd1, 16'h002F, 8'h00, 8'h17}, // R8 revision
    {4'd8,  2'd0, 16'h002E, 8'h23, 8'h00}, // R8
    {4'd8,  2'd1, 16'h002F, 8'h00, 8'h19}, // R8 mfr high
    {4'd8,  2'd0, 16'h002F, 8'hEE, 8'h00}, // R8 write ignored
    {4'd8,  2'd1, 16'h002F, 8'h00, 8'h19}, // R8
    {4'd8,  2'd0, 16'h002E, 8'h24, 8'h00}, // R8
    {4'd8,  2'd1, 16'h002F, 8'h00, 8'h34}, // R8 mfr low
    {4'd7,  2'd0, 16'h002E, 8'h07, 8'h00}, // R7
    {4'd7,  2'd0, 16'h002F, 8'h06, 8'h00}, // R7
    {4'd7,  2'd3, 16'h0000, 8'h00, 8'h06}, // R7
    {4'd7,  2'd1, 16'h002F, 8'h00, 8'h06}, // R7 readback
    {4'd12, 2'd1, 16'h002E, 8'h00, 8'h07}, // R12 index read
    {4'd9,  2'd0, 16'h002E, 8'h35, 8'h00}, // R9
    {4'd9,  2'd1, 16'h002F, 8'h00, 8'h6F}, // R9 forwarded read
    {4'd10, 2'd0, 16'h002E, 8'h2F, 8'h00}, // R10
    {4'd10, 2'd1, 16'h002F, 8'h00, 8'h00}, // R10 unassigned global
    {4'd6,  2'd1, 16'h03F0, 8'h00, 8'hFF}, // R6 miss read
    {4'd6,  2'd0, 16'h004E, 8'hAA, 8'h00}  // R6 miss write
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic do_reset(input logic alt);
    @(negedge clk);
    rst_n = 1'b0; strap_alt = alt;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    n_checks = 0; n_fail = 0; done = 1'b0;
    io_addr = 16'h0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = 8'h0;
    rst_n = 1'b0; strap_alt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cfg_open", {7'd0, cfg_open}, 8'h00);
    check("R1 ld_sel", ld_sel, 8'h00);
    check("R1 io_rdata", io_rdata, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][37:34], i);
      case (VEC[i][33:32])
        2'd0: do_wr(VEC[i][31:16], VEC[i][15:8]);
        2'd1: begin do_rd(VEC[i][31:16], r); check(tag, r, VEC[i][7:0]); end
        2'd2: check(tag, {7'd0, cfg_open}, VEC[i][7:0]);
        default: check(tag, ld_sel, VEC[i][7:0]);
      endcase
    end
    // R6 miss write left port open
    check("R6 miss write", {7'd0, cfg_open}, 8'h01);

    // R11 read data holds over idle cycles
    repeat (4) @(negedge clk);
    check("R11 hold", io_rdata, 8'hFF);

    // R9 forwarded write strobe
    do_wr(16'h002E, 8'h40);
    @(negedge clk);
    io_addr = 16'h002F; io_wdata = 8'h9C; io_wr = 1'b1;
    #1;
    check("R9 dev_wr", {7'd0, dev_wr}, 8'h01);
    check("R9 dev_idx", dev_idx, 8'h40);
    check("R9 dev_wdata", dev_wdata, 8'h9C);
    @(negedge clk);
    io_wr = 1'b0;
    #1;
    check("R9 single cycle", {7'd0, dev_wr}, 8'h00);

    // R10 global index never forwards
    do_wr(16'h002E, 8'h07);
    @(negedge clk);
    io_addr = 16'h002F; io_wdata = 8'h03; io_rd = 1'b0; io_wr = 1'b1;
    #1;
    check("R10 dev_wr", {7'd0, dev_wr}, 8'h00);
    @(negedge clk);
    io_wr = 1'b0;
    check("R7 ld_sel", ld_sel, 8'h03);

    // R4 exit key then closed reads
    do_wr(16'h002E, 8'hAA);
    check("R4 closed", {7'd0, cfg_open}, 8'h00);
    do_rd(16'h002F, r);
    check("R4 closed read", r, 8'hFF);
    check("R4 ld_sel kept", ld_sel, 8'h03);

    // R6 alternate base
    do_reset(1'b1);
    do_wr(16'h002E, 8'h87);
    do_wr(16'h002E, 8'h87);
    check("R6 primary ignored", {7'd0, cfg_open}, 8'h00);
    do_wr(16'h004E, 8'h87);
    do_wr(16'h004E, 8'h87);
    check("R6 alt open", {7'd0, cfg_open}, 8'h01);
    do_wr(16'h004E, 8'h21);
    do_rd(16'h004F, r);
    check("R6 alt data", r, 8'hA5);

    finish_run();
  end

endmodule